// File: doc/BRIEF.md
# Page-Mode Multiplexed-Address DRAM Controller

This block turns word requests from a cache refill port into strobe sequences on a DRAM with a shared address bus. A request gives a start address, a read/write flag and a burst length. The controller splits the address into a row part and a column part. It presents the row with the row strobe, then presents each column with its own column strobe pulse. It then returns read words, or takes write words, one per column access.

The policy is open-page. After a request the row strobe stays asserted, so a later request to the same row skips the row phase and pays only the column time. A request to a different row first closes the open row for one cycle.

A free-running interval counter raises a refresh request. The refresh is served at the next request boundary: the front end is held off, any open row is closed, and the refresh strobe is driven for a fixed number of cycles. A burst that would step past the last column of its row is cut at the row end and flagged.

Top module: `pagedram_ctrl`

## Requirements
- R1: The request address carries the row in its upper ROW_W bits and the column in its lower COL_W bits. The row is presented on `mem_addr` when `row_strb` rises. Each column is presented on `mem_addr` while `col_strb` is high, and is held stable for the whole pulse.
- R2: When no row is open, the first word of a request completes T_ROW cycles after the accepting clock edge. Each further word of that request completes T_COL cycles after the one before it. For a read, "completes" means the cycle in which `rd_valid` is high.
- R3: A request to the row that is already open skips the row phase, and its first word completes T_COL cycles after acceptance.
- R4: A request to a different row while a row is open spends one cycle with `row_strb` low, so its first word completes T_ROW+1 cycles after acceptance.
- R5: `row_strb` stays high for all words of a request and after the request ends. Between words, `col_strb` drops low for exactly one cycle while `row_strb` stays high.
- R6: Read words are returned with a one-cycle `rd_valid` pulse each, one per column access, at columns that rise by one from the start column.
- R7: For a write, `wr_next` pulses in the last strobe cycle of each column access, one cycle before that word's completion slot. The value on `wr_data` during that access is stored at the word's column, and a later read returns it.
- R8: `req_len` is the word count minus one. If start column + word count exceeds 2^COL_W, only the words up to the last column are transferred, and `burst_err` pulses in the cycle after acceptance.
- R9: A refresh is requested every T_REF cycles. While it is pending or running, `req_ready` is low. `mem_refresh` stays high for exactly T_RFC cycles, and its rising edges are T_REF cycles apart while no requests arrive.
- R10: `row_strb` is low when `mem_refresh` rises. The first request after a refresh therefore pays the full row time.
- R11: After reset, `req_ready` is high, and `row_strb`, `col_strb`, `mem_refresh` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ROW_W+COL_W | Start address: row in the upper bits, column in the lower bits |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W | Word count minus one |
| wr_data | input | DATA_W | Current write word |
| wr_next | output | 1 | Current write word is taken this cycle |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DATA_W | Read word |
| burst_err | output | 1 | Accepted burst was cut at the row end |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| row_strb | output | 1 | Row strobe, active high |
| col_strb | output | 1 | Column strobe, active high |
| mem_write | output | 1 | Write enable during a column pulse |
| mem_refresh | output | 1 | Refresh strobe |
| mem_dq_out | output | DATA_W | Data to the DRAM |
| mem_dq_in | input | DATA_W | Data from the DRAM |

## Verification
Each result has a fixed due cycle, counted from the clock edge that accepts the request:
- `burst_err` is due in cycle 1.
- The first `rd_valid` is due at T_ROW, T_COL or T_ROW+1, depending on whether the row was closed, already open, or a different row was open.
- Each later word is due T_COL cycles after the one before it.
- Each `wr_next` is due one cycle before its word's slot.

At acceptance the bench pushes these due cycles into queues, working out the row state from its own tracking of open rows and observed refreshes. On every falling edge it compares `rd_valid`, `wr_next` and `burst_err` with the head of each queue. A pulse that arrives early, late or not at all is therefore reported. Refresh spacing and length are measured edge to edge on `mem_refresh` during an idle stretch.

// File: rtl/pagedram_ctrl.sv
module pagedram_ctrl #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 3,
  parameter int T_ROW  = 6,
  parameter int T_COL  = 3,
  parameter int T_REF  = 150,
  parameter int T_RFC  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic                     req_write,
  input  logic [LEN_W-1:0]         req_len,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     wr_next,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     burst_err,
  output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] mem_addr,
  output logic                     row_strb,
  output logic                     col_strb,
  output logic                     mem_write,
  output logic                     mem_refresh,
  output logic [DATA_W-1:0]        mem_dq_out,
  input  logic [DATA_W-1:0]        mem_dq_in
);
  localparam int PA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int NCOL = 1 << COL_W;
  localparam int WW   = ((COL_W > LEN_W) ? COL_W : LEN_W) + 1;
  localparam int TMAX = (T_ROW > T_RFC) ? T_ROW : T_RFC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(T_REF + 1);

  typedef enum logic [2:0] {S_IDLE, S_CLOSE, S_ROW, S_COL, S_REF} st_t;

  st_t              st;
  logic [TW-1:0]    cnt;
  logic [ROW_W-1:0] row_q, open_row;
  logic [COL_W-1:0] col_q;
  logic [WW-1:0]    left_q;
  logic             we_q, open_q, go_ref, ref_pend;
  logic [RW-1:0]    ref_cnt;
  logic             rd_v_q, err_q;
  logic [DATA_W-1:0] rd_q;

  wire [ROW_W-1:0] in_row = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] in_col = req_addr[COL_W-1:0];
  wire [WW-1:0]    room   = WW'(NCOL) - WW'(in_col);
  wire [WW-1:0]    want   = WW'(req_len) + WW'(1);
  wire             cut    = want > room;

  assign req_ready   = (st == S_IDLE) && !ref_pend;
  assign row_strb    = (st == S_ROW) || (st == S_COL) || ((st == S_IDLE) && open_q);
  assign col_strb    = (st == S_COL) && (cnt != '0);
  assign mem_write   = col_strb && we_q;
  assign wr_next     = (st == S_COL) && (cnt == TW'(1)) && we_q;
  assign mem_refresh = (st == S_REF);
  assign mem_dq_out  = wr_data;
  assign mem_addr    = (st == S_COL) ? PA_W'(col_q) : PA_W'(row_q);
  assign rd_valid    = rd_v_q;
  assign rd_data     = rd_q;
  assign burst_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  row_q <= '0;  open_row <= '0;  col_q <= '0;
      left_q <= '0;  we_q <= 1'b0;  open_q <= 1'b0;  go_ref <= 1'b0;
      ref_pend <= 1'b0;  ref_cnt <= '0;  rd_v_q <= 1'b0;  err_q <= 1'b0;  rd_q <= '0;
    end else begin
      rd_v_q <= 1'b0;
      err_q  <= 1'b0;
      if (ref_cnt == RW'(T_REF - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + RW'(1);
      end
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            if (open_q) begin
              st <= S_CLOSE;  go_ref <= 1'b1;
            end else begin
              st <= S_REF;  cnt <= TW'(T_RFC - 1);
            end
          end else if (req_valid) begin
            row_q  <= in_row;
            col_q  <= in_col;
            we_q   <= req_write;
            left_q <= cut ? room : want;
            err_q  <= cut;
            if (open_q && open_row == in_row) begin
              st <= S_COL;  cnt <= TW'(T_COL - 1);
            end else if (open_q) begin
              st <= S_CLOSE;  go_ref <= 1'b0;
            end else begin
              st <= S_ROW;  cnt <= TW'(T_ROW - T_COL - 1);
            end
          end
        end
        S_CLOSE: begin
          open_q <= 1'b0;
          if (go_ref) begin
            st <= S_REF;  cnt <= TW'(T_RFC - 1);
          end else begin
            st <= S_ROW;  cnt <= TW'(T_ROW - T_COL - 1);
          end
        end
        S_ROW: begin
          if (cnt == '0) begin
            st <= S_COL;  cnt <= TW'(T_COL - 1);
            open_q <= 1'b1;  open_row <= row_q;
          end else begin
            cnt <= cnt - TW'(1);
          end
        end
        S_COL: begin
          if (cnt == TW'(1) && !we_q) begin
            rd_v_q <= 1'b1;
            rd_q   <= mem_dq_in;
          end
          if (cnt == '0) begin
            if (left_q == WW'(1)) begin
              st <= S_IDLE;
            end else begin
              left_q <= left_q - WW'(1);
              col_q  <= col_q + COL_W'(1);
              cnt    <= TW'(T_COL - 1);
            end
          end else begin
            cnt <= cnt - TW'(1);
          end
        end
        S_REF: begin
          if (cnt == '0) begin
            st <= S_IDLE;  ref_pend <= 1'b0;
          end else begin
            cnt <= cnt - TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  col_after_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_strb) |-> $past(row_strb));
  // R5
  row_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col_strb) |-> row_strb);
  // R1
  col_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_strb && $past(col_strb)) |-> $stable(mem_addr));
  // R10
  ref_row_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_refresh) |-> !$past(row_strb));
  // R6
  rd_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(col_strb));
  // R8
  err_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err |-> $past(req_valid && req_ready));
endmodule

// File: tb/test_pagedram_ctrl.sv
module test_pagedram_ctrl;
  localparam int T_ROW = 6, T_COL = 3, T_REF = 150, T_RFC = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [6:0] req_addr = '0;
  logic [2:0] req_len = '0;
  logic [15:0] wr_data = '0;
  logic req_ready, wr_next, rd_valid, burst_err, row_strb, col_strb, mem_write, mem_refresh;
  logic [15:0] rd_data, mem_dq_out, mem_dq_in;
  logic [3:0] mem_addr;

  always #2 clk = ~clk;

  pagedram_ctrl #(.ROW_W(4), .COL_W(3), .DATA_W(16), .LEN_W(3), .T_ROW(T_ROW),
    .T_COL(T_COL), .T_REF(T_REF), .T_RFC(T_RFC)) i_pagedram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_len(req_len), .wr_data(wr_data),
    .wr_next(wr_next), .rd_valid(rd_valid), .rd_data(rd_data), .burst_err(burst_err),
    .mem_addr(mem_addr), .row_strb(row_strb), .col_strb(col_strb), .mem_write(mem_write),
    .mem_refresh(mem_refresh), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in));

  // behavioural DRAM
  logic [15:0] dmem [0:127];
  logic [3:0] lrow = '0;
  logic rs_q = 0;
  assign mem_dq_in = col_strb ? dmem[{lrow, mem_addr[2:0]}] : 16'h0;
  always @(posedge clk) begin
    rs_q <= row_strb;
    if (row_strb && !rs_q) lrow <= mem_addr;
    if (col_strb && mem_write) dmem[{lrow, mem_addr[2:0]}] <= mem_dq_out;
  end

  typedef struct { int due; logic [15:0] d; } ev_t;
  ev_t rdq[$];
  int wrq[$];
  logic [15:0] wdq[$];
  logic [15:0] ref_mem [0:127];
  int cyc = 0, nchk = 0, nerr = 0, err_due = -1;
  bit open_v = 0, took = 0, wpop = 0, done = 0, col_prev = 0, ref_prev = 0, spacing_on = 0;
  int open_row = 0, seed = 0, ref_run = 0, last_rise = -1, rises = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", req, act, exp, cyc);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    if (wpop && wdq.size() > 0) begin void'(wdq.pop_front()); wpop = 0; end
    wr_data = (wdq.size() > 0) ? wdq[0] : 16'h0;
  end

  always @(negedge clk) if (rst_n) begin
    bit e;
    e = rdq.size() > 0 && rdq[0].due == cyc;
    chk(rd_valid == e, "R2 R3 R4 R6 read slot", int'(rd_valid), int'(e));
    if (e) begin
      if (rd_valid) chk(rd_data == rdq[0].d, "R1 R6 R7 read data", int'(rd_data), int'(rdq[0].d));
      void'(rdq.pop_front());
    end
    e = wrq.size() > 0 && wrq[0] == cyc;
    chk(wr_next == e, "R7 write slot", int'(wr_next), int'(e));
    if (e) begin void'(wrq.pop_front()); wpop = 1; end
    e = (err_due == cyc);
    chk(burst_err == e, "R8 burst_err", int'(burst_err), int'(e));
    if (col_prev && !col_strb) chk(row_strb, "R5 row held between words", int'(row_strb), 1);
    col_prev = col_strb;
    if (mem_refresh) begin
      open_v = 0;
      chk(!req_ready, "R9 ready low in refresh", int'(req_ready), 0);
      ref_run++;
    end
    if (mem_refresh && !ref_prev) begin
      chk(!row_strb, "R10 row closed at refresh", int'(row_strb), 0);
      rises++;
      if (spacing_on && rises >= 3) chk(cyc - last_rise == T_REF, "R9 refresh spacing", cyc - last_rise, T_REF);
      last_rise = cyc;
    end
    if (!mem_refresh && ref_prev) begin
      chk(ref_run == T_RFC, "R9 refresh length", ref_run, T_RFC);
      ref_run = 0;
    end
    ref_prev = mem_refresh;
    if (req_valid && req_ready) begin
      int row, col, words, base;
      row = int'(req_addr[6:3]);  col = int'(req_addr[2:0]);
      words = int'(req_len) + 1;
      if (col + words > 8) begin words = 8 - col; err_due = cyc + 1; end
      base = (open_v && open_row == row) ? T_COL : (open_v ? T_ROW + 1 : T_ROW);
      for (int k = 0; k < words; k++) begin
        int due;
        due = cyc + base + k * T_COL;
        if (req_write) begin
          logic [15:0] d;
          d = 16'(seed * 16 + k + 1);
          wdq.push_back(d);
          wrq.push_back(due - 1);
          ref_mem[row * 8 + col + k] = d;
        end else begin
          rdq.push_back('{due, ref_mem[row * 8 + col + k]});
        end
      end
      open_v = 1;  open_row = row;  took = 1;
    end
  end

  task automatic req(input int row, input int col, input int len, input bit wr);
    @(posedge clk); #1;
    seed++;
    req_addr = 7'(row * 8 + col);  req_len = 3'(len);  req_write = wr;  req_valid = 1;
    took = 0;
    do begin @(posedge clk); #1; end while (!took);
    req_valid = 0;
  endtask

  task automatic drain();
    while (rdq.size() > 0 || wrq.size() > 0 || !req_ready) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin dmem[i] = 16'h0; ref_mem[i] = 16'h0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready, "R11 ready", int'(req_ready), 1);
    chk(!row_strb && !col_strb, "R11 strobes", int'(row_strb | col_strb), 0);
    chk(!mem_refresh && !rd_valid, "R11 refresh/valid", int'(mem_refresh | rd_valid), 0);
    rst_n = 1;
    req(3, 0, 3, 1);          // R2 R7 closed-row write burst
    req(3, 0, 3, 0);          // R3 R6 page-hit read
    req(3, 2, 1, 0);          // R3
    req(5, 4, 1, 1);          // R4 row change
    req(3, 1, 2, 0);          // R4
    req(5, 6, 3, 0);          // R8 truncated
    req(9, 7, 0, 1);          // R8 single word at last column, no error
    req(9, 5, 7, 0);          // R8
    drain();
    spacing_on = 1;  rises = 0;
    repeat (3 * T_REF + 20) @(posedge clk);   // R9 R10 idle refresh
    spacing_on = 0;
    req(5, 4, 1, 0);          // R10 full row cost after refresh
    req(12, 0, 7, 1);         // R6 R7 full-row write
    req(12, 0, 7, 0);
    req(12, 3, 0, 0);
    req(0, 0, 0, 0);
    drain();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;  nchk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule